// File: doc/BRIEF.md
# Branch and Address Generation Unit

This unit owns program flow and data addressing for a small 8-bit processor with a 16-bit address space. Each cycle in which the decoder presents a retiring instruction (`instr_valid` high), the unit updates the program counter. It advances by one for ordinary instructions. It adds a signed 8-bit displacement for relative jumps, takes the YX register pair for absolute jumps, or steps over the following instruction when a conditional skip finds the flag set.

For a jump-and-link, the unit also produces the return address and a one-cycle write enable. The register file uses these to load the YX pair. For memory instructions, the unit forms the effective address in one of three modes. The single condition flag selects the direction: when it is set the access is a write, and when it is clear the access is a read. The strobe is presented for one cycle. The data memory sits outside the unit.

All address arithmetic wraps modulo 65536. Relative targets are measured from the address of the instruction that follows the current one.

Top module: `bagu_top`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` becomes `RESET_PC` (default 0) and `mem_rd`, `mem_wr` and `link_we` become 0.
- R2: With `instr_valid` low, `pc` holds its value. With `instr_valid` high and `cmd` = 0 (plain), or the unused codes 6 and 7, `pc` becomes `pc+1`.
- R3: Relative jump (`cmd` = 1) sets `pc` to `pc + 1 + sign_extend(operand)`, wrapping modulo 65536.
- R4: Jump-and-link (`cmd` = 2) moves `pc` as in R3. In the same cycle it sets `link_data` to the old `pc+1` and pulses `link_we` for one cycle.
- R5: Absolute jump (`cmd` = 3) sets `pc` to `yx`.
- R6: Conditional skip (`cmd` = 4) sets `pc` to `pc+2` when `flag` is 1 and to `pc+1` when `flag` is 0, wrapping modulo 65536.
- R7: Memory instruction (`cmd` = 5) sets `pc` to `pc+1`. It sets `mem_addr` by `amode`: 0 gives `pc + 1 + sign_extend(operand)`, 1 gives `dp + sign_extend(operand)`, and 2 or 3 gives `yx`. All sums wrap modulo 65536.
- R8: A memory instruction with `flag` = 1 raises `mem_wr`, and one with `flag` = 0 raises `mem_rd`. The strobe is high in the cycle after the instruction, and `mem_rd` and `mem_wr` are never high together.
- R9: After any cycle that does not retire a memory instruction, `mem_rd` and `mem_wr` are 0. After any cycle that does not retire a jump-and-link, `link_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction retires this cycle |
| cmd | input | 3 | Flow command: 0 plain, 1 jump, 2 jump-and-link, 3 absolute jump, 4 skip, 5 memory |
| amode | input | 2 | Addressing mode for memory: 0 PC-relative, 1 DP-relative, 2/3 YX |
| operand | input | 8 | Signed displacement |
| yx | input | 16 | YX register pair |
| dp | input | 16 | Frame register |
| flag | input | 1 | Condition flag |
| pc | output | 16 | Program counter |
| link_data | output | 16 | Return address for YX |
| link_we | output | 1 | Write enable for the return address |
| mem_addr | output | 16 | Effective data address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
A jump-and-link does two things in the same cycle: it redirects the PC and it captures the link value. Both are derived from one incremented PC. In addition, a PC-relative memory access must compute its address from the same PC that it advances. The bench provokes these cases by placing jump-and-link and PC-relative memory instructions back to back. Some are placed near the top and bottom of the address space, and others are mixed into random streams. One sample after each edge, the bench judges `pc`, `link_data` and `mem_addr` together against a model PC.

// File: rtl/bagu_pkg.sv
package bagu_pkg;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int CW = 3;
    localparam int MW = 2;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] data_t;

    typedef enum logic [CW-1:0] {
        CMD_NEXT  = 3'd0,
        CMD_JUMP  = 3'd1,
        CMD_JLINK = 3'd2,
        CMD_LJUMP = 3'd3,
        CMD_SKIP  = 3'd4,
        CMD_MEM   = 3'd5,
        CMD_RSV6  = 3'd6,
        CMD_RSV7  = 3'd7
    } cmd_e;

    typedef enum logic [MW-1:0] {
        AM_PCREL = 2'd0,
        AM_DPREL = 2'd1,
        AM_YX    = 2'd2,
        AM_YX2   = 2'd3
    } amode_e;

    typedef struct packed {
        addr_t addr;
        logic  rd;
        logic  wr;
    } mem_req_t;

    typedef struct packed {
        addr_t data;
        logic  we;
    } link_t;

    function automatic addr_t sext_off(input data_t v);
        return {{(AW-DW){v[DW-1]}}, v};
    endfunction
endpackage

// File: rtl/bagu_next_pc.sv
module bagu_next_pc
    import bagu_pkg::*;
(
    input  logic  valid,
    input  cmd_e  cmd,
    input  addr_t pc,
    input  addr_t yx,
    input  data_t operand,
    input  logic  flag,
    output addr_t seq_pc,
    output addr_t pc_next,
    output link_t link
);
    addr_t rel_tgt;
    addr_t skip_tgt;

    always_comb begin
        seq_pc   = pc + addr_t'(1);
        rel_tgt  = seq_pc + sext_off(operand);
        skip_tgt = pc + addr_t'(2);
    end

    always_comb begin
        pc_next   = pc;
        link.data = seq_pc;
        link.we   = 1'b0;
        if (valid) begin
            unique case (cmd)
                CMD_JUMP:  pc_next = rel_tgt;
                CMD_JLINK: begin
                    pc_next = rel_tgt;
                    link.we = 1'b1;
                end
                CMD_LJUMP: pc_next = yx;
                CMD_SKIP:  pc_next = flag ? skip_tgt : seq_pc;
                default:   pc_next = seq_pc;
            endcase
        end
    end
endmodule

// File: rtl/bagu_agen.sv
module bagu_agen
    import bagu_pkg::*;
(
    input  logic   valid,
    input  cmd_e   cmd,
    input  amode_e amode,
    input  addr_t  seq_pc,
    input  addr_t  dp,
    input  addr_t  yx,
    input  data_t  operand,
    input  logic   flag,
    output mem_req_t req
);
    addr_t off;
    logic  is_mem;

    always_comb begin
        off    = sext_off(operand);
        is_mem = valid && (cmd == CMD_MEM);
        unique case (amode)
            AM_PCREL: req.addr = seq_pc + off;
            AM_DPREL: req.addr = dp + off;
            default:  req.addr = yx;
        endcase
        req.wr = is_mem && flag;
        req.rd = is_mem && !flag;
    end
endmodule

// File: rtl/bagu_top.sv
module bagu_top
    import bagu_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        instr_valid,
    input  logic [2:0]  cmd,
    input  logic [1:0]  amode,
    input  logic [7:0]  operand,
    input  logic [15:0] yx,
    input  logic [15:0] dp,
    input  logic        flag,
    output logic [15:0] pc,
    output logic [15:0] link_data,
    output logic        link_we,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    output logic        mem_wr
);
    cmd_e     cmd_q;
    amode_e   am_q;
    addr_t    pc_r;
    addr_t    seq_pc;
    addr_t    pc_nx;
    link_t    link_nx;
    link_t    link_r;
    mem_req_t req_nx;
    mem_req_t req_r;

    assign cmd_q = cmd_e'(cmd);
    assign am_q  = amode_e'(amode);

    bagu_next_pc u_npc (
        .valid   (instr_valid),
        .cmd     (cmd_q),
        .pc      (pc_r),
        .yx      (yx),
        .operand (operand),
        .flag    (flag),
        .seq_pc  (seq_pc),
        .pc_next (pc_nx),
        .link    (link_nx)
    );

    bagu_agen u_agen (
        .valid   (instr_valid),
        .cmd     (cmd_q),
        .amode   (am_q),
        .seq_pc  (seq_pc),
        .dp      (dp),
        .yx      (yx),
        .operand (operand),
        .flag    (flag),
        .req     (req_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_r        <= RESET_PC;
            link_r.we   <= 1'b0;
            link_r.data <= '0;
            req_r.rd    <= 1'b0;
            req_r.wr    <= 1'b0;
            req_r.addr  <= '0;
        end else begin
            pc_r      <= pc_nx;
            link_r.we <= link_nx.we;
            if (link_nx.we) link_r.data <= link_nx.data;
            req_r.rd  <= req_nx.rd;
            req_r.wr  <= req_nx.wr;
            if (req_nx.rd || req_nx.wr) req_r.addr <= req_nx.addr;
        end
    end

    assign pc        = pc_r;
    assign link_data = link_r.data;
    assign link_we   = link_r.we;
    assign mem_addr  = req_r.addr;
    assign mem_rd    = req_r.rd;
    assign mem_wr    = req_r.wr;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pc == RESET_PC) && !mem_rd && !mem_wr && !link_we);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(pc));

    // R4
    link_value_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && cmd == 3'd2) |=> link_we && (link_data == addr_t'($past(pc) + 16'd1)));

    // R5
    abs_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && cmd == 3'd3) |=> (pc == $past(yx)));

    // R6
    skip_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && cmd == 3'd4 && flag) |=> (pc == addr_t'($past(pc) + 16'd2)));

    // R7
    yx_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && cmd == 3'd5 && amode[1]) |=> (mem_addr == $past(yx)));

    // R8
    strobe_mutex_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R8
    dir_by_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && cmd == 3'd5) |=> (mem_wr == $past(flag)) && (mem_rd == !$past(flag)));

    // R9
    no_stray_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(instr_valid && cmd == 3'd5) |=> !mem_rd && !mem_wr);

    // R9
    no_stray_link_chk: assert property (@(posedge clk) disable iff (rst)
        !(instr_valid && cmd == 3'd2) |=> !link_we);
endmodule

// File: tb/tb_bagu_top.sv
`timescale 1ns/1ps
module tb_bagu_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [2:0]  cmd;
    logic [1:0]  amode;
    logic [7:0]  operand;
    logic [15:0] yx;
    logic [15:0] dp;
    logic        flag;
    logic [15:0] pc;
    logic [15:0] link_data;
    logic        link_we;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_pc;

    always #2.5 clk = ~clk;

    bagu_top dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .cmd(cmd), .amode(amode),
        .operand(operand), .yx(yx), .dp(dp), .flag(flag), .pc(pc),
        .link_data(link_data), .link_we(link_we), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    function automatic logic [15:0] sx(input logic [7:0] v);
        return {{8{v[7]}}, v};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] c, input logic [1:0] m,
                        input logic [7:0] o, input logic f,
                        input logic [15:0] y, input logic [15:0] d);
        logic [15:0] seq, npc, eaddr;
        logic erd, ewr, elwe;
        @(negedge clk);
        instr_valid = v; cmd = c; amode = m; operand = o; flag = f; yx = y; dp = d;
        seq = exp_pc + 16'd1;
        npc = exp_pc; eaddr = '0; erd = 0; ewr = 0; elwe = 0;
        if (v) begin
            case (c)
                3'd1: npc = seq + sx(o);                      // R3
                3'd2: begin npc = seq + sx(o); elwe = 1; end  // R4
                3'd3: npc = y;                                // R5
                3'd4: npc = f ? exp_pc + 16'd2 : seq;         // R6
                3'd5: begin                                   // R7
                    npc = seq;
                    eaddr = (m == 2'd0) ? seq + sx(o) : (m == 2'd1) ? d + sx(o) : y;
                    ewr = f; erd = !f;
                end
                default: npc = seq;                           // R2
            endcase
        end
        @(posedge clk); #1;
        case (v ? c : 3'd0)
            3'd1: chk("R3 jump pc", pc, npc);
            3'd2: chk("R4 jlink pc", pc, npc);
            3'd3: chk("R5 abs pc", pc, npc);
            3'd4: chk("R6 skip pc", pc, npc);
            3'd5: chk("R7 mem pc", pc, npc);
            default: chk("R2 pc", pc, npc);
        endcase
        chk("R8 R9 mem_rd", mem_rd, erd);
        chk("R8 R9 mem_wr", mem_wr, ewr);
        chk("R4 R9 link_we", link_we, elwe);
        if (erd || ewr) chk("R7 mem_addr", mem_addr, eaddr);
        if (elwe) chk("R4 link_data", link_data, seq);
        exp_pc = npc;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1; instr_valid = 0; cmd = 0; amode = 0; operand = 0; yx = 0; dp = 0; flag = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1
        chk("R1 reset pc", pc, 16'h0000);
        chk("R1 reset rd", mem_rd, 0);
        chk("R1 reset wr", mem_wr, 0);
        chk("R1 reset link_we", link_we, 0);
        @(negedge clk); rst = 0;
        exp_pc = 16'h0000;

        // directed corners
        step(0, 3'd1, 0, 8'h10, 0, 0, 0);              // R2 idle hold
        step(1, 3'd0, 0, 0, 0, 0, 0);                  // R2 plain
        step(1, 3'd6, 0, 0, 1, 0, 0);                  // R2 unused code
        step(1, 3'd1, 0, 8'h80, 0, 0, 0);              // R3 backward wrap below zero
        step(1, 3'd1, 0, 8'h7F, 0, 0, 0);              // R3 forward wrap
        step(1, 3'd3, 0, 0, 0, 16'hFFFF, 0);           // R5 to top
        step(1, 3'd0, 0, 0, 0, 0, 0);                  // R2 wrap to 0
        step(1, 3'd3, 0, 0, 0, 16'hFFFE, 0);           // R5
        step(1, 3'd4, 0, 0, 1, 0, 0);                  // R6 skip wraps
        step(1, 3'd4, 0, 0, 0, 0, 0);                  // R6 not taken
        step(1, 3'd2, 0, 8'hFE, 0, 0, 0);              // R4 link then redirect
        step(1, 3'd5, 0, 8'hFF, 1, 0, 0);              // R7 R8 pc-rel write
        step(1, 3'd2, 0, 8'h05, 0, 0, 0);              // R4 back to back with mem
        step(1, 3'd5, 1, 8'h80, 0, 16'h1234, 16'h0010); // R7 dp wrap, read
        step(1, 3'd5, 2, 8'h33, 1, 16'hBEEF, 0);        // R7 yx
        step(1, 3'd5, 3, 8'h33, 0, 16'hCAFE, 0);        // R7 yx alt
        step(1, 3'd7, 0, 0, 1, 0, 0);                  // R9 strobes drop

        // random
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 6) != 0, 3'($urandom % 8), 2'($urandom % 4), 8'($urandom),
                 1'($urandom % 2), 16'($urandom), 16'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule